// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port Controller

This block controls one port of eight general-purpose I/O pins through a small synchronous register bus. Every pin owns a control byte that picks its mode (input, output, or hand-over to an alternate on-chip function) and its pull resistor. A port-wide data register holds the levels that output pins drive, and a port-wide open-drain select register turns a driven high into a released line on the pins that select it.

Towards the pad the block presents, per pin, an output value, an output enable and pull-up and pull-down requests, and it takes the resolved pad level back. That level is what a read of the data register returns, so software always sees the real state of the line rather than the stored output value. Pins handed to the alternate function are driven straight from the alternate path, and the pad level is returned to that path.

The bus is a single-cycle strobe: a write lands on the next clock edge and a read returns its byte one cycle after the strobe. The port's control bytes sit at offset `PORT_IDX*8+8`, one byte per pin in pin order; the data register sits at offset 0 and the open-drain register at offset 1.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every control byte reads 0x80 (input, no pull), the open-drain register reads 0x00 and the stored output levels are 0; no pin drives its pad and no pull is requested.
- R2: The control byte of pin i lives at bus offset PORT_IDX*8+8+i (offsets 8..15 for the default port 0); a write there stores all eight bits, reads back unchanged, and affects only pin i.
- R3: With control bits [7:6] = 2'b10, and also with the unused code 2'b11, the pin is an input: its output enable is 0.
- R4: With control bits [7:6] = 2'b01 and its open-drain bit clear, the pin drives: output enable 1 and pad output equal to its bit of the data register.
- R5: With control bits [7:6] = 2'b01 and its bit set in the open-drain register (offset 1), a stored 1 releases the line (output enable 0) and a stored 0 drives the pad low.
- R6: With control bits [7:6] = 2'b00 the pad output and enable come from the alternate path, ignoring the data and open-drain registers, and the pin's alternate input returns the pad level; in any other mode the alternate input is 0.
- R7: Control bit 2 requests a pull-up and bit 1 a pull-down; when both are set only the pull-up is requested, and when both are clear neither is.
- R8: Writing the data register while pins are inputs changes no output enable; a pin later switched to output drives the value stored earlier.
- R9: A read of offset 0 returns the pad levels sampled at the strobe edge, a read of offset 1 returns the open-drain register; each read byte appears on the read port one cycle after the strobe.
- R10: Writes to unmapped offsets change no register, and reads of unmapped offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid the cycle after a read strobe |
| alt_out | input | PINS | Alternate-function output values |
| alt_oe | input | PINS | Alternate-function output enables |
| alt_in | output | PINS | Pad levels returned to the alternate function |
| pad_in | input | PINS | Resolved pad levels |
| pad_out | output | PINS | Pad output values |
| pad_oe | output | PINS | Pad output enables |
| pad_pu | output | PINS | Pull-up requests |
| pad_pd | output | PINS | Pull-down requests |

## Verification
The bench goes after the mode decode at its edges: the unused direction code 2'b11, which a careless decode would treat as output and drive the line, and the all-clear code, where a design that kept the data path would ignore the alternate function. It drives open-drain pins with mixed data so that a design that dropped the open-drain qualifier shows a driven high, and sets both pull bits so that a design without the pull-up priority requests both resistors at once. It preloads the data register while pins are inputs, which catches a design that drives on a data write or that loses the stored level, and it reads the data register with pulls and external levels mixed so that returning the stored value instead of the pad level is visible.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int CTRL_W      = 8;
  localparam int DATA_OFS    = 0;
  localparam int ODSEL_OFS   = 1;
  localparam int CTRL_STRIDE = 8;
  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h80;

  typedef enum logic [1:0] {
    PM_IN  = 2'd0,
    PM_OUT = 2'd1,
    PM_ALT = 2'd2
  } pin_mode_e;

  // Direction bits are control bits [7:6]; 2'b11 is treated as input.
  function automatic pin_mode_e decode_mode(input logic [1:0] dir_bits);
    case (dir_bits)
      2'b01:   decode_mode = PM_OUT;
      2'b00:   decode_mode = PM_ALT;
      default: decode_mode = PM_IN;
    endcase
  endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int PINS      = 8,
  parameter int ADDR_W    = 8,
  parameter int CTRL_BASE = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [CTRL_W-1:0]             wdata,
  input  logic [PINS-1:0]               pad_lvl,
  output logic [CTRL_W-1:0]             rdata,
  output logic [PINS-1:0][CTRL_W-1:0]   ctrl_q,
  output logic [PINS-1:0]               od_q,
  output logic [PINS-1:0]               data_q
);

  logic              wr_data;
  logic              wr_od;
  logic [PINS-1:0]   wr_ctrl;
  logic              rd_en;
  logic [CTRL_W-1:0] rd_d;
  logic [CTRL_W-1:0] rdata_q;

  // Write decode
  assign wr_data = sel & we & (addr == ADDR_W'(DATA_OFS));
  assign wr_od   = sel & we & (addr == ADDR_W'(ODSEL_OFS));
  assign rd_en   = sel & ~we;

  for (genvar i = 0; i < PINS; i++) begin : g_wdec
    assign wr_ctrl[i] = sel & we & (addr == ADDR_W'(CTRL_BASE + i));
  end

  // Read mux (next state of the read register)
  always_comb begin
    rd_d = '0;
    if (addr == ADDR_W'(DATA_OFS)) begin
      rd_d[PINS-1:0] = pad_lvl;
    end else if (addr == ADDR_W'(ODSEL_OFS)) begin
      rd_d[PINS-1:0] = od_q;
    end else begin
      for (int i = 0; i < PINS; i++) begin
        if (addr == ADDR_W'(CTRL_BASE + i)) rd_d = ctrl_q[i];
      end
    end
  end

  // Registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (wr_data) begin
      data_q <= wdata[PINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_q <= '0;
    end else if (wr_od) begin
      od_q <= wdata[PINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PINS; i++) ctrl_q[i] <= CTRL_RST;
    end else begin
      for (int i = 0; i < PINS; i++) begin
        if (wr_ctrl[i]) ctrl_q[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_d;
    end
  end

  assign rdata = rdata_q;

  // R8
  data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we && addr == ADDR_W'(DATA_OFS)) |=> (data_q == $past(wdata[PINS-1:0])));

  // R9
  rd_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !we && addr == ADDR_W'(DATA_OFS)) |=> (rdata[PINS-1:0] == $past(pad_lvl)));

  // R10
  od_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && we && addr == ADDR_W'(ODSEL_OFS)) |=> $stable(od_q));

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] dir_bits,
  input  logic       pu_bit,
  input  logic       pd_bit,
  input  logic       od_sel,
  input  logic       out_val,
  input  logic       alt_out,
  input  logic       alt_oe,
  input  logic       pad_lvl,
  output logic       pad_out,
  output logic       pad_oe,
  output logic       pad_pu,
  output logic       pad_pd,
  output logic       alt_in
);

  pin_mode_e mode;

  assign mode = decode_mode(dir_bits);

  always_comb begin
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    alt_in  = 1'b0;
    case (mode)
      PM_OUT: begin
        pad_out = od_sel ? 1'b0 : out_val;
        pad_oe  = od_sel ? ~out_val : 1'b1;
      end
      PM_ALT: begin
        pad_out = alt_out;
        pad_oe  = alt_oe;
        alt_in  = pad_lvl;
      end
      default: begin
        pad_out = 1'b0;
        pad_oe  = 1'b0;
      end
    endcase
  end

  // Pull-up has priority over pull-down
  assign pad_pu = pu_bit;
  assign pad_pd = pd_bit & ~pu_bit;

  // R3
  in_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_bits[1] |-> !pad_oe);

  // R5
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_bits == 2'b01 && od_sel && out_val) |-> !pad_oe);

  // R6
  alt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_bits == 2'b00) |-> (pad_oe == alt_oe && pad_out == alt_out));

  // R7
  pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pad_pu && pad_pd));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int PORT_IDX = 0,
  parameter int PINS     = 8,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [PINS-1:0]   alt_out,
  input  logic [PINS-1:0]   alt_oe,
  output logic [PINS-1:0]   alt_in,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_pu,
  output logic [PINS-1:0]   pad_pd
);

  localparam int CTRL_BASE = PORT_IDX * CTRL_STRIDE + CTRL_STRIDE;

  logic [1:0]                rst_sync_q;
  logic                      rst_int_n;
  logic [PINS-1:0][CTRL_W-1:0] ctrl_q;
  logic [PINS-1:0]           od_q;
  logic [PINS-1:0]           data_q;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  gpio_port_regs #(
    .PINS      (PINS),
    .ADDR_W    (ADDR_W),
    .CTRL_BASE (CTRL_BASE)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sel     (bus_sel),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .pad_lvl (pad_in),
    .rdata   (bus_rdata),
    .ctrl_q  (ctrl_q),
    .od_q    (od_q),
    .data_q  (data_q)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    gpio_pin_slice u_pin (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .dir_bits (ctrl_q[i][7:6]),
      .pu_bit   (ctrl_q[i][2]),
      .pd_bit   (ctrl_q[i][1]),
      .od_sel   (od_q[i]),
      .out_val  (data_q[i]),
      .alt_out  (alt_out[i]),
      .alt_oe   (alt_oe[i]),
      .pad_lvl  (pad_in[i]),
      .pad_out  (pad_out[i]),
      .pad_oe   (pad_oe[i]),
      .pad_pu   (pad_pu[i]),
      .pad_pd   (pad_pd[i]),
      .alt_in   (alt_in[i])
    );
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (pad_oe == '0 && pad_pu == '0 && pad_pd == '0));

endmodule

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;

  localparam int PINS = 8;
  localparam int AW   = 8;

  logic          clk;
  logic          rst_n;
  logic          bus_sel;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic [7:0]    bus_rdata;
  logic [PINS-1:0] alt_out, alt_oe, alt_in;
  logic [PINS-1:0] pad_in, pad_out, pad_oe, pad_pu, pad_pd;
  logic [PINS-1:0] ext_lvl;

  int n_chk  = 0;
  int n_fail = 0;

  gpio_port_ctrl #(.PORT_IDX(0), .PINS(PINS), .ADDR_W(AW)) u_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Pad model: driven level, else pull, else external level
  always_comb begin
    for (int i = 0; i < PINS; i++) begin
      if (pad_oe[i])      pad_in[i] = pad_out[i];
      else if (pad_pu[i]) pad_in[i] = 1'b1;
      else if (pad_pd[i]) pad_in[i] = 1'b0;
      else                pad_in[i] = ext_lvl[i];
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_all_ctrl(input logic [7:0] v);
    for (int i = 0; i < PINS; i++) bus_write(8'(8 + i), v);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    for (int i = 0; i < PINS; i++) begin
      bus_read(8'(8 + i), r);
      chk("R1 ctrl reset", r, 8'h80);
    end
    bus_read(8'h01, r);
    chk("R1 od reset", r, 8'h00);
    chk("R1 oe reset", pad_oe, 8'h00);
    chk("R1 pulls reset", pad_pu | pad_pd, 8'h00);
    bus_write(8'h0B, 8'h40);
    chk("R1 stored level zero", {pad_oe[3], pad_out[3]}, 8'h02);
    bus_write(8'h0B, 8'h80);
  endtask

  task automatic t_ctrl_map();
    logic [7:0] r;
    for (int i = 0; i < PINS; i++) bus_write(8'(8 + i), 8'(8'h88 + i));
    for (int i = 0; i < PINS; i++) begin
      bus_read(8'(8 + i), r);
      chk("R2 ctrl readback", r, 8'(8'h88 + i));
    end
    set_all_ctrl(8'h80);
    bus_write(8'h0D, 8'h40);
    chk("R2 pin5 only", pad_oe, 8'h20);
    bus_write(8'h0D, 8'h80);
  endtask

  task automatic t_input();
    logic [7:0] r;
    bus_write(8'h00, 8'hFF);
    ext_lvl = 8'h00;
    bus_write(8'h0A, 8'h80);
    chk("R3 input 10 no drive", pad_oe, 8'h00);
    bus_write(8'h0A, 8'hC0);
    chk("R3 code 11 no drive", pad_oe, 8'h00);
    bus_read(8'h00, r);
    chk("R3 input level from ext", r, 8'h00);
    bus_write(8'h0A, 8'h80);
  endtask

  task automatic t_output();
    bus_write(8'h00, 8'hA5);
    set_all_ctrl(8'h40);
    chk("R4 oe all", pad_oe, 8'hFF);
    chk("R4 out A5", pad_out, 8'hA5);
    bus_write(8'h00, 8'h5A);
    chk("R4 out 5A", pad_out, 8'h5A);
  endtask

  task automatic t_open_drain();
    logic [7:0] r;
    ext_lvl = 8'h0F;
    bus_write(8'h00, 8'hA5);
    bus_write(8'h01, 8'hFF);
    chk("R5 oe released on ones", pad_oe, 8'h5A);
    chk("R5 driven low", pad_out & pad_oe, 8'h00);
    bus_read(8'h00, r);
    chk("R9 od pad level", r, 8'h05);
    bus_read(8'h01, r);
    chk("R9 od readback", r, 8'hFF);
  endtask

  task automatic t_alt();
    alt_out = 8'h3C; alt_oe = 8'hF0;
    set_all_ctrl(8'h00);
    chk("R6 alt oe", pad_oe, 8'hF0);
    chk("R6 alt out", pad_out, 8'h3C);
    chk("R6 alt in", alt_in, 8'h3F);
    bus_write(8'h08, 8'h80);
    chk("R6 alt in gated", alt_in, 8'h3E);
    bus_write(8'h01, 8'h00);
    set_all_ctrl(8'h80);
    chk("R6 alt released", pad_oe, 8'h00);
  endtask

  task automatic t_pull();
    logic [7:0] r;
    ext_lvl = 8'hFF;
    bus_write(8'h09, 8'h84);
    chk("R7 pu only", {pad_pu[1], pad_pd[1]}, 8'h02);
    bus_write(8'h09, 8'h82);
    chk("R7 pd only", {pad_pu[1], pad_pd[1]}, 8'h01);
    bus_read(8'h00, r);
    chk("R7 pd level", r, 8'hFD);
    bus_write(8'h09, 8'h86);
    chk("R7 both pu wins", {pad_pu[1], pad_pd[1]}, 8'h02);
    bus_write(8'h09, 8'h80);
    chk("R7 none", {pad_pu[1], pad_pd[1]}, 8'h00);
  endtask

  task automatic t_preload();
    bus_write(8'h00, 8'h96);
    chk("R8 no drive on preload", pad_oe, 8'h00);
    bus_write(8'h0C, 8'h40);
    chk("R8 oe pin4", pad_oe, 8'h10);
    chk("R8 preloaded level", {7'b0, pad_out[4]}, 8'h01);
    bus_write(8'h0C, 8'h80);
  endtask

  task automatic t_read_latency();
    logic [7:0] r;
    ext_lvl = 8'hC3;
    bus_read(8'h00, r);
    chk("R9 ext read", r, 8'hC3);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 8'h01;
    chk("R9 no change before edge", bus_rdata, 8'hC3);
    @(negedge clk);
    bus_sel = 1'b0;
    chk("R9 od after edge", bus_rdata, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] r;
    for (int a = 2; a < 8; a++) bus_write(8'(a), 8'hFF);
    bus_write(8'h10, 8'hFF);
    bus_write(8'h7F, 8'h47);
    bus_read(8'h01, r);
    chk("R10 od untouched", r, 8'h00);
    for (int i = 0; i < PINS; i++) begin
      bus_read(8'(8 + i), r);
      chk("R10 ctrl untouched", r, 8'h80);
    end
    bus_read(8'h05, r);
    chk("R10 unmapped read", r, 8'h00);
    bus_read(8'h10, r);
    chk("R10 unmapped above", r, 8'h00);
    chk("R10 no drive", pad_oe, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    alt_out = '0; alt_oe = '0; ext_lvl = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctrl_map();
    t_input();
    t_output();
    t_open_drain();
    t_alt();
    t_pull();
    t_preload();
    t_read_latency();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule